// File: doc/BRIEF.md
# Priority Interrupt Controller, 64 Level-Sensitive Sources

This block gathers 64 level-sensitive interrupt request lines and keeps choosing one winner to present to the processor. The winner is given as a 3-bit priority level and an 8-bit vector number. Each source has a programmable control byte, which sets both the source's rank and whether it takes part at all. A 64-bit mask also gates each source, one bit per source. The request lines are captured every clock into a pending register.

Software reaches the block over a simple 32-bit register bus with an 8-bit offset. Through it, software can:
- read the pending and force words;
- program the two mask halves and the 64 control bytes;
- read the current vector at a software acknowledge location.

The force register has no write path and always reads as zero, but it still feeds the candidate logic. A write to an offset that cannot be written raises a one-cycle bad-access flag and is otherwise dropped. Writes to the pending words are the exception: they are dropped silently.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Source n is a candidate only when (pending[n] OR force[n]) is 1, its control byte is nonzero, and mask bit n is 0. A mask bit of 1 blocks the source.
- R2: Among the candidates, the one with the largest 8-bit control byte wins. When control bytes are equal, the higher-numbered source wins.
- R3: The vector output is the winner's index plus 64, and the level output is bits [2:0] of the winner's control byte. With no candidate, the vector is 24 and the level is 0.
- R4: Each clock, pending bit n takes the value of input line n, both setting and clearing. Pending reads at offset 0x00 (sources 63..32) and 0x04 (sources 31..0). Writes to these two offsets change nothing and raise no flag.
- R5: The mask reads and writes at 0x08 (sources 63..32) and 0x0C (sources 31..0). A write replaces only the addressed half.
- R6: The control byte of source n sits at offset 0x40+n. A write stores write-data bits [7:0], and a read returns that byte zero-extended.
- R7: A read at 0xE0 returns the current vector output. Reads of the force words (0x10, 0x14) and of every unmapped offset return 0.
- R8: A write to any offset other than 0x00, 0x04, 0x08, 0x0C or 0x40..0x7F sets the bad-access flag for exactly one clock after the write edge and changes no state.
- R9: Synchronous reset sets every mask bit to 1 and clears pending, force and all control bytes. After reset the vector is 24, the level is 0 and the bad-access flag is 0.
- R10: Level and vector are registered. They reflect a register write one clock after the write edge, and an input change two clocks after it: one clock for pending capture, one for the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Level-sensitive request lines |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from offset |
| bad_access | output | 1 | One-cycle flag for a write to a non-writable offset |
| cpu_level | output | 3 | Priority level presented to the processor |
| cpu_vector | output | 8 | Vector number presented to the processor |

## Verification
The bench sets up a tie between two sources with equal control bytes and expects the higher index to win. A design that resolves ties toward the lower index would report vector 69 instead of 74. It also drives a control byte of 9 against two bytes of 3, so it expects level 1 and a full-byte comparison. A design that ranks by the 3-bit level alone would pick a different winner.

Writes to one mask half are followed by a read of the other half, which catches a whole-word overwrite. Writes to the force words, the acknowledge location and a misaligned offset must raise the flag for one clock and leave the readable state as it was. Each output is sampled one and two clocks after its cause, so an extra or a missing pipeline stage shows up as a stale or early vector.

// File: rtl/irqc_pkg.sv
// Package: shared types, offsets and the arbitration merge for the
// interrupt controller. Assumes at most 64 sources.
package irqc_pkg;
    localparam int IDX_W  = 6;
    localparam int PRI_W  = 8;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_PEND_HI = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND_LO = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MASK_HI = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK_LO = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_FORC_HI = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_FORC_LO = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'hE0;

    // One contender in the arbitration tree
    typedef struct packed {
        logic             vld;
        logic [PRI_W-1:0] pri;
        logic [IDX_W-1:0] idx;
    } irqc_node_t;

    // Merge two contenders; hi covers higher source numbers and wins ties
    function automatic irqc_node_t irqc_merge(input irqc_node_t lo,
                                              input irqc_node_t hi);
        if (hi.vld && (!lo.vld || hi.pri >= lo.pri))
            return hi;
        return lo;
    endfunction
endpackage

// File: rtl/irqc_regs.sv
// Register file: pending capture, mask halves, control bytes, read mux
// and write decode with the bad-access flag. Assumes N_SRC <= 64 and
// a power of two; the low 8 address bits form the offset.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [7:0]        cur_vector,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bad_access,
    output logic [N_SRC-1:0]  pend_q,
    output logic [N_SRC-1:0]  force_w,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  en_q,
    output logic [N_SRC*PRI_W-1:0] ctrl_flat
);
    localparam int SEL_W = $clog2(N_SRC);

    logic [63:0] mask64_q;
    logic [63:0] pend64;
    logic [63:0] mask64_view;
    logic [PRI_W-1:0] ctrl_q [N_SRC];
    logic in_ctrl, is_pend, is_mask_hi, is_mask_lo, wr_ok;
    logic [SEL_W-1:0] ctrl_sel;

    assign force_w     = '0;
    assign mask_q      = mask64_q[N_SRC-1:0];
    assign pend64      = 64'(pend_q);
    assign mask64_view = mask64_q;
    assign in_ctrl     = (bus_addr >= OFS_CTRL) &&
                         (bus_addr < OFS_CTRL + ADDR_W'(N_SRC));
    assign ctrl_sel    = SEL_W'(bus_addr - OFS_CTRL);
    assign is_pend     = (bus_addr == OFS_PEND_HI) || (bus_addr == OFS_PEND_LO);
    assign is_mask_hi  = (bus_addr == OFS_MASK_HI);
    assign is_mask_lo  = (bus_addr == OFS_MASK_LO);
    assign wr_ok       = is_pend || is_mask_hi || is_mask_lo || in_ctrl;

    // Pending follows the request lines each clock
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= irq_in;
    end

    // Mask halves, each written independently
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask64_q <= '1;
        end else if (bus_sel && bus_wr) begin
            if (is_mask_hi) mask64_q[63:32] <= bus_wdata;
            if (is_mask_lo) mask64_q[31:0]  <= bus_wdata;
        end
    end

    // One control byte and enable bit per source
    for (genvar s = 0; s < N_SRC; s++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctrl_q[s] <= '0;
                en_q[s]   <= 1'b0;
            end else if (bus_sel && bus_wr && in_ctrl &&
                         ctrl_sel == SEL_W'(s)) begin
                ctrl_q[s] <= bus_wdata[PRI_W-1:0];
                en_q[s]   <= |bus_wdata[PRI_W-1:0];
            end
        end
        assign ctrl_flat[s*PRI_W +: PRI_W] = ctrl_q[s];
    end

    // Flag writes to offsets that cannot be written
    always_ff @(posedge clk) begin
        if (!rst_n) bad_access <= 1'b0;
        else        bad_access <= bus_sel && bus_wr && !wr_ok;
    end

    // Read data, zero for force words and unmapped offsets
    always_comb begin
        bus_rdata = '0;
        if (in_ctrl) begin
            bus_rdata = DATA_W'(ctrl_q[ctrl_sel]);
        end else begin
            case (bus_addr)
                OFS_PEND_HI: bus_rdata = pend64[63:32];
                OFS_PEND_LO: bus_rdata = pend64[31:0];
                OFS_MASK_HI: bus_rdata = mask64_view[63:32];
                OFS_MASK_LO: bus_rdata = mask64_view[31:0];
                OFS_ACK:     bus_rdata = DATA_W'(cur_vector);
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_arb.sv
// Arbiter: reduces the candidate set to one winner through a binary
// tree of merges. Higher control byte wins; ties go to the higher
// index. Assumes N_SRC is a power of two.
module irqc_arb
    import irqc_pkg::*;
#(
    parameter int N_SRC = 64
) (
    input  logic [N_SRC-1:0]       cand,
    input  logic [N_SRC*PRI_W-1:0] ctrl_flat,
    output irqc_node_t             winner
);
    localparam int NODES = 2*N_SRC - 1;

    irqc_node_t node [NODES];

    // Fill leaves in source order, then merge pairs up to the root
    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            node[N_SRC-1+s].vld = cand[s];
            node[N_SRC-1+s].pri = ctrl_flat[s*PRI_W +: PRI_W];
            node[N_SRC-1+s].idx = IDX_W'(s);
        end
        for (int i = N_SRC-2; i >= 0; i--)
            node[i] = irqc_merge(node[2*i+1], node[2*i+2]);
    end

    assign winner = node[0];
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: 64-source priority interrupt controller. Builds the candidate
// set, arbitrates, and registers level and vector toward the processor.
module irq_prio_ctrl
    import irqc_pkg::*;
#(
    parameter int N_SRC    = 64,
    parameter int VEC_BASE = 64,
    parameter int IDLE_VEC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  irq_in,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bad_access,
    output logic [2:0]        cpu_level,
    output logic [7:0]        cpu_vector
);
    logic [N_SRC-1:0]       pend_q, force_w, mask_q, en_q, cand;
    logic [N_SRC*PRI_W-1:0] ctrl_flat;
    irqc_node_t             winner;
    logic                   cand_any;

    irqc_regs #(.N_SRC(N_SRC)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .cur_vector(cpu_vector),
        .bus_rdata(bus_rdata), .bad_access(bad_access),
        .pend_q(pend_q), .force_w(force_w), .mask_q(mask_q),
        .en_q(en_q), .ctrl_flat(ctrl_flat)
    );

    // Candidate set: requested, enabled and unmasked
    assign cand = (pend_q | force_w) & en_q & ~mask_q;

    irqc_arb #(.N_SRC(N_SRC)) u_arb (
        .cand(cand), .ctrl_flat(ctrl_flat), .winner(winner)
    );

    assign cand_any = winner.vld;

    // Output stage toward the processor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_level  <= '0;
            cpu_vector <= 8'(IDLE_VEC);
        end else if (winner.vld) begin
            cpu_level  <= winner.pri[2:0];
            cpu_vector <= 8'(VEC_BASE) + 8'(winner.idx);
        end else begin
            cpu_level  <= '0;
            cpu_vector <= 8'(IDLE_VEC);
        end
    end
endmodule

// File: rtl/irqc_checker.sv
// Checker: temporal properties of the controller, bound to the top.
module irqc_checker #(
    parameter int N_SRC    = 64,
    parameter int VEC_BASE = 64,
    parameter int IDLE_VEC = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_in,
    input logic [N_SRC-1:0] pend_q,
    input logic [N_SRC-1:0] mask_q,
    input logic             cand_any,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             bad_access,
    input logic [2:0]       cpu_level,
    input logic [7:0]       cpu_vector
);
    AST_IDLE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !cand_any |=> (cpu_vector == 8'(IDLE_VEC) && cpu_level == 3'd0)); // R3
    AST_WINNER_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        cand_any |=> (cpu_vector >= 8'(VEC_BASE) &&
                      cpu_vector < 8'(VEC_BASE + N_SRC))); // R1
    AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pend_q == $past(irq_in)); // R4
    AST_MASK_LO_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 8'h08) |=> $stable(mask_q[31:0])); // R5
    AST_BAD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_access |-> $past(bus_sel && bus_wr)); // R8
    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (&mask_q && pend_q == '0)); // R9
endmodule

bind irq_prio_ctrl irqc_checker #(
    .N_SRC(N_SRC), .VEC_BASE(VEC_BASE), .IDLE_VEC(IDLE_VEC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .pend_q(pend_q),
    .mask_q(mask_q), .cand_any(cand_any), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bad_access(bad_access),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
);

// File: tb/tb_irq_prio_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_irq_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bad_access;
    logic [2:0]  cpu_level;
    logic [7:0]  cpu_vector;

    int checks = 0;
    int errors = 0;
    logic last_bad;
    bit done = 1'b0;

    irq_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bad_access(bad_access),
        .cpu_level(cpu_level), .cpu_vector(cpu_vector)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        last_bad = bad_access;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [7:0] v,
                              input logic [2:0] l);
        check({req, " vector"}, 32'(cpu_vector), 32'(v));
        check({req, " level"},  32'(cpu_level),  32'(l));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        expect_out("R9 reset", 8'd24, 3'd0);
        check("R9 bad flag", 32'(bad_access), 32'd0);
        bus_read(8'h08, d); check("R9 mask hi", d, 32'hFFFF_FFFF);
        bus_read(8'h0C, d); check("R9 mask lo", d, 32'hFFFF_FFFF);
        bus_read(8'h00, d); check("R9 pend hi", d, 32'h0);
        bus_read(8'h45, d); check("R9 ctrl byte", d, 32'h0);
        bus_read(8'hE0, d); check("R9 ack vector", d, 32'd24);
    endtask

    task automatic t_pending();
        logic [31:0] d;
        irq_in = (64'd1 << 40) | (64'd1 << 3);
        tick(2);
        bus_read(8'h00, d); check("R4 pend hi", d, 32'h100);
        bus_read(8'h04, d); check("R4 pend lo", d, 32'h8);
        expect_out("R1 pending but disabled", 8'd24, 3'd0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        check("R4 pend write no flag", 32'(last_bad), 32'd0);
        bus_read(8'h04, d); check("R4 pend write ignored", d, 32'h8);
        irq_in = '0;
        tick(2);
        bus_read(8'h04, d); check("R4 pend clears", d, 32'h0);
    endtask

    task automatic t_timing();
        bus_write(8'h45, 32'd3);
        bus_write(8'h0C, 32'hFFFF_FFDF);
        check("R5 mask write no flag", 32'(last_bad), 32'd0);
        tick(1);
        expect_out("R1 enabled unmasked not pending", 8'd24, 3'd0);
        irq_in[5] = 1'b1;
        tick(1);
        expect_out("R10 one clock after input", 8'd24, 3'd0);
        tick(1);
        expect_out("R10 two clocks after input", 8'd69, 3'd3);
        bus_write(8'h0C, 32'hFFFF_FFFF);
        expect_out("R10 at write edge", 8'd69, 3'd3);
        tick(1);
        expect_out("R1 masked source", 8'd24, 3'd0);
        bus_write(8'h0C, 32'hFFFF_FFDF);
        tick(1);
        expect_out("R1 unmasked again", 8'd69, 3'd3);
    endtask

    task automatic t_arb();
        bus_write(8'h4A, 32'd3);
        bus_write(8'h42, 32'd9);
        bus_write(8'h0C, 32'hFFFF_FBDB);
        irq_in[2] = 1'b1; irq_in[10] = 1'b1;
        tick(2);
        expect_out("R2 full byte wins", 8'd66, 3'd1);
        bus_write(8'h42, 32'd0);
        tick(1);
        expect_out("R2 tie to higher index", 8'd74, 3'd3);
        bus_write(8'h4A, 32'd0);
        tick(1);
        expect_out("R1 zero byte disables", 8'd69, 3'd3);
    endtask

    task automatic t_high();
        logic [31:0] d;
        bus_write(8'h7F, 32'd7);
        bus_write(8'h08, 32'h7FFF_FFFF);
        irq_in[63] = 1'b1;
        tick(2);
        expect_out("R3 top source", 8'd127, 3'd7);
        bus_read(8'hE0, d); check("R7 ack read", d, 32'd127);
        bus_read(8'h0C, d); check("R5 low half kept", d, 32'hFFFF_FBDB);
        bus_read(8'h08, d); check("R5 high half", d, 32'h7FFF_FFFF);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        bus_write(8'h51, 32'h0000_01A5);
        bus_read(8'h51, d); check("R6 ctrl byte stored", d, 32'hA5);
        bus_read(8'h50, d); check("R6 neighbour byte", d, 32'h0);
    endtask

    task automatic t_bad();
        logic [31:0] d;
        bus_write(8'h10, 32'hFFFF_FFFF);
        check("R8 force write flagged", 32'(last_bad), 32'd1);
        tick(1);
        check("R8 flag one cycle", 32'(bad_access), 32'd0);
        bus_read(8'h10, d); check("R7 force hi reads 0", d, 32'h0);
        bus_read(8'h14, d); check("R7 force lo reads 0", d, 32'h0);
        bus_write(8'hE0, 32'h0);
        check("R8 ack write flagged", 32'(last_bad), 32'd1);
        bus_read(8'hE0, d); check("R8 ack unchanged", d, 32'd127);
        bus_write(8'h0E, 32'h0);
        check("R8 misaligned flagged", 32'(last_bad), 32'd1);
        bus_read(8'h0C, d); check("R8 mask untouched", d, 32'hFFFF_FBDB);
        bus_read(8'h90, d); check("R7 unmapped reads 0", d, 32'h0);
    endtask

    task automatic t_idle();
        irq_in = '0;
        tick(2);
        expect_out("R3 idle after release", 8'd24, 3'd0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_pending();
        t_timing();
        t_arb();
        t_high();
        t_ctrl();
        t_bad();
        t_idle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule